// File: doc/BRIEF.md
# Disk-Adapter CPU Bus Decoder

This block is the processor-facing front of a console disk-drive adapter. It watches an 8-bit data, 16-bit address bus with separate read and write strobes. It steers each access into one of several regions: a byte-wide work RAM, a BIOS ROM window, a 64-entry wave table, a bank of sixteen audio control bytes, a drive status port, an I/O enable byte and a control byte. Bit 3 of the control byte sets the nametable mirroring output.

Each region behaves differently on a read. Wave-table entries keep only six bits. Status reads return fixed values. Audio control bytes and the two setup bytes cannot be read back by the processor. Every address that the map does not claim reads as zero. Read data is registered, so it appears one clock after the read strobe for every region.

The BIOS contents arrive through a separate byte-serial load port before the processor runs. BIOS reads wrap modulo the number of bytes loaded. The stored audio bytes and setup bytes are driven out as plain outputs for the neighbouring synthesis and drive logic.

Top module: `disk_bus_decoder`

## Requirements
- R1: Writes anywhere in $6000–$DFFF store a byte that reads back from the same address. Storage holds 2^WRAM_AW bytes (default 11), indexed by the low WRAM_AW bits of (address − $6000), so $6800 aliases $6000 by default.
- R2: A read at $E000–$FFFF returns loaded byte number ((address − $E000) mod L), where L is the count of bytes loaded. When L is 0 the read returns 0.
- R3: Each cycle with bios_ld_valid high stores bios_ld_data at position L and increments L, until L reaches 2^BIOS_AW (default 1024). Bytes offered after that are dropped. bios_ld_restart sets L to 0 and takes priority over bios_ld_valid.
- R4: A write to $4040–$407F stores cpu_wdata[5:0] in entry (address − $4040). A read returns {2'b00, entry}.
- R5: A write to $4080+k (k = 0..15) stores the byte in audio_bank[8k+7:8k]. Reads of $4080–$408F return 0.
- R6: A read of $4030 returns $80. Reads of $4031, $4032 and $4033 return 0.
- R7: A write to $4025 stores the byte on ctrl_byte and sets mirror_horiz to bit 3 of it (1 = horizontal, 0 = vertical). A read of $4025 returns 0.
- R8: A write to $4023 stores the byte on io_enable and changes nothing else.
- R9: Reads of any address not named in R1–R8 return 0. Writes to such addresses, including $4030, change no output and no stored byte.
- R10: cpu_rdata takes the addressed value at the clock edge that samples cpu_rd, and holds it while cpu_rd is low. A read and a write to the same address in one cycle return the value stored before the write.
- R11: While rst_n is low at a clock edge, the following are cleared: the work RAM contents as read, the wave table, the audio bank, io_enable, ctrl_byte, cpu_rdata and L. mirror_horiz is set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | 8 | Registered read data |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |
| io_enable | output | 8 | Stored I/O enable byte |
| ctrl_byte | output | 8 | Stored control byte |
| audio_bank | output | 128 | Sixteen audio control bytes, byte k at bits 8k+7:8k |
| bios_ld_valid | input | 1 | BIOS load byte strobe |
| bios_ld_data | input | 8 | BIOS load byte |
| bios_ld_restart | input | 1 | Restart BIOS loading at position 0 |

## Verification
The decoder is tried with several kinds of traffic:
- Writes followed by reads at both ends of the work RAM window. These tell correct offsetting apart from off-by-one region edges.
- Wave-table writes with all-ones and mixed data. These separate masking on write from masking on read.
- Reads of write-only, status and undecoded addresses next to live ones. These show whether a region leaks stored data.
- Partial and over-full BIOS loads, read at offsets beyond the loaded length. These distinguish true modulo wrapping from plain truncation and from an unsaturated length.
- A same-cycle read and write, a read followed by idle cycles, and a reset after traffic. These pin down the read timing and what the reset clears.

// File: rtl/dbd_pkg.sv
// Package: shared address map, region codes and sizes for the disk-adapter
// bus decoder. Assumes a 16-bit address and 8-bit data bus.
package dbd_pkg;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_WRAM,
        RG_BIOS,
        RG_WAVE,
        RG_AUDIO,
        RG_STAT,
        RG_IOEN,
        RG_CTRL
    } region_e;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;

    localparam logic [15:0] WRAM_LO  = 16'h6000;
    localparam logic [15:0] WRAM_HI  = 16'hDFFF;
    localparam logic [15:0] BIOS_LO  = 16'hE000;
    localparam logic [15:0] WAVE_LO  = 16'h4040;
    localparam logic [15:0] WAVE_HI  = 16'h407F;
    localparam logic [15:0] AUD_LO   = 16'h4080;
    localparam logic [15:0] AUD_HI   = 16'h408F;
    localparam logic [15:0] STAT_AD  = 16'h4030;
    localparam logic [15:0] IOEN_AD  = 16'h4023;
    localparam logic [15:0] CTRL_AD  = 16'h4025;

    localparam logic [7:0]  STAT_NOT_READY = 8'h80;
    localparam int          MIRROR_BIT     = 3;

    localparam int BIOS_WIN_W = 13;
    localparam int WAVE_N     = 64;
    localparam int WAVE_DW    = 6;
    localparam int WAVE_IW    = $clog2(WAVE_N);
    localparam int AUD_N      = 16;
    localparam int AUD_IW     = $clog2(AUD_N);

endpackage

// File: rtl/dbd_addr_decode.sv
// Module: dbd_addr_decode
// Maps a bus address to the region that owns it. Pure combinational logic.
// Assumes the regions in dbd_pkg do not overlap, so no priority is needed.
module dbd_addr_decode
    import dbd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);

    // Compare the address against each region bound.
    always_comb begin
        region = RG_NONE;
        if (addr >= WRAM_LO && addr <= WRAM_HI)      region = RG_WRAM;
        else if (addr >= BIOS_LO)                    region = RG_BIOS;
        else if (addr >= WAVE_LO && addr <= WAVE_HI) region = RG_WAVE;
        else if (addr >= AUD_LO && addr <= AUD_HI)   region = RG_AUDIO;
        else if (addr == STAT_AD)                    region = RG_STAT;
        else if (addr == IOEN_AD)                    region = RG_IOEN;
        else if (addr == CTRL_AD)                    region = RG_CTRL;
    end

endmodule

// File: rtl/dbd_work_ram.sv
// Module: dbd_work_ram
// Byte-wide work RAM with a combinational read port. Each entry has a valid
// bit. Reset clears all valid bits in one cycle, so entries read as zero
// until written, and the data array needs no reset.
// Assumes one write per cycle; the caller qualifies wr_en with its region.
module dbd_work_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] vld;

    // Store write data; the array itself is never reset.
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) mem[idx] <= wdata;
    end

    // Track which entries were written since the last reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld      <= '0;
        else if (wr_en) vld[idx] <= 1'b1;
    end

    // Unwritten entries read as zero.
    assign rdata = vld[idx] ? mem[idx] : '0;

endmodule

// File: rtl/dbd_bios_rom.sv
// Module: dbd_bios_rom
// BIOS store, filled byte by byte through a load port. A window offset reads
// byte (offset mod loaded length). An empty store reads zero.
// Assumes the load finishes before the processor reads the window.
module dbd_bios_rom #(
    parameter int AW    = 10,
    parameter int OFF_W = 13,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_restart,
    input  logic             ld_valid,
    input  logic [DW-1:0]    ld_data,
    input  logic [OFF_W-1:0] offset,
    output logic [DW-1:0]    rdata
);

    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   len_q;
    logic          take;
    logic [AW-1:0] rd_idx;

    // Remainder by restoring long division, one bit of the offset per step.
    function automatic logic [AW-1:0] f_mod(input logic [OFF_W-1:0] n,
                                            input logic [AW:0] d);
        logic [AW:0] r;
        r = '0;
        for (int i = OFF_W - 1; i >= 0; i--) begin
            r = {r[AW-1:0], n[i]};
            if (r >= d) r = r - d;
        end
        return r[AW-1:0];
    endfunction

    assign take = ld_valid && !ld_restart && (len_q != FULL);

    // Count loaded bytes; restart wins over a byte offered in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          len_q <= '0;
        else if (ld_restart) len_q <= '0;
        else if (take)       len_q <= len_q + 1'b1;
    end

    // Store an accepted load byte at the current length.
    always_ff @(posedge clk) begin
        if (rst_n && take) mem[len_q[AW-1:0]] <= ld_data;
    end

    assign rd_idx = f_mod(offset, len_q);
    assign rdata  = (len_q == '0) ? '0 : mem[rd_idx];

endmodule

// File: rtl/dbd_wave_table.sv
// Module: dbd_wave_table
// Small register-based table with reset-to-zero entries of reduced width.
// Writes keep only the low DW bits of the bus data.
// Assumes the caller qualifies wr_en with the table's region.
module dbd_wave_table #(
    parameter int N  = 64,
    parameter int DW = 6,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] tbl [N];

    // Clear every entry on reset, otherwise store the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[idx] <= wdata;
        end
    end

    assign rdata = tbl[idx];

endmodule

// File: rtl/disk_bus_decoder.sv
// Module: disk_bus_decoder (top)
// Processor-side decoder and register file of a disk-drive adapter. It routes
// accesses to work RAM, BIOS window, wave table, audio bank, status, I/O enable
// and control byte, drives the mirroring output, and registers read data so
// every region answers one clock after the read strobe.
// Assumes single-cycle strobes. A read and write in the same cycle return the
// value held before the write.
module disk_bus_decoder
    import dbd_pkg::*;
#(
    parameter int WRAM_AW = 11,
    parameter int BIOS_AW = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [15:0]         cpu_addr,
    input  logic [7:0]          cpu_wdata,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    output logic [7:0]          cpu_rdata,
    output logic                mirror_horiz,
    output logic [7:0]          io_enable,
    output logic [7:0]          ctrl_byte,
    output logic [AUD_N*8-1:0]  audio_bank,
    input  logic                bios_ld_valid,
    input  logic [7:0]          bios_ld_data,
    input  logic                bios_ld_restart
);

    region_e             region;
    logic [DATA_W-1:0]   wram_rd;
    logic [DATA_W-1:0]   bios_rd;
    logic [WAVE_DW-1:0]  wave_rd;
    logic [DATA_W-1:0]   rd_mux;
    logic [DATA_W-1:0]   rdata_q;
    logic                mirror_q;
    logic [DATA_W-1:0]   ioen_q;
    logic [DATA_W-1:0]   ctrl_q;
    logic [DATA_W-1:0]   aud_q [AUD_N];
    logic                aud_we;
    logic [AUD_IW-1:0]   aud_idx;

    dbd_addr_decode u_dec (
        .addr   (cpu_addr),
        .region (region)
    );

    dbd_work_ram #(.AW(WRAM_AW), .DW(DATA_W)) u_wram (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_wr && region == RG_WRAM),
        .idx   (WRAM_AW'(cpu_addr - WRAM_LO)),
        .wdata (cpu_wdata),
        .rdata (wram_rd)
    );

    dbd_bios_rom #(.AW(BIOS_AW), .OFF_W(BIOS_WIN_W), .DW(DATA_W)) u_bios (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_restart (bios_ld_restart),
        .ld_valid   (bios_ld_valid),
        .ld_data    (bios_ld_data),
        .offset     (BIOS_WIN_W'(cpu_addr - BIOS_LO)),
        .rdata      (bios_rd)
    );

    dbd_wave_table #(.N(WAVE_N), .DW(WAVE_DW), .IW(WAVE_IW)) u_wave (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cpu_wr && region == RG_WAVE),
        .idx   (WAVE_IW'(cpu_addr - WAVE_LO)),
        .wdata (cpu_wdata[WAVE_DW-1:0]),
        .rdata (wave_rd)
    );

    assign aud_we  = cpu_wr && region == RG_AUDIO;
    assign aud_idx = AUD_IW'(cpu_addr - AUD_LO);

    // One write-only byte register per audio slot, exported on the flat bus.
    for (genvar g = 0; g < AUD_N; g++) begin : g_aud
        always_ff @(posedge clk) begin
            if (!rst_n)                                aud_q[g] <= '0;
            else if (aud_we && aud_idx == AUD_IW'(g))  aud_q[g] <= cpu_wdata;
        end
        assign audio_bank[g*8 +: 8] = aud_q[g];
    end

    // Setup bytes and the mirroring flag taken from control bit 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ioen_q   <= '0;
            ctrl_q   <= '0;
            mirror_q <= 1'b1;
        end else if (cpu_wr) begin
            if (region == RG_IOEN) ioen_q <= cpu_wdata;
            if (region == RG_CTRL) begin
                ctrl_q   <= cpu_wdata;
                mirror_q <= cpu_wdata[MIRROR_BIT];
            end
        end
    end

    // Select the read value of the addressed region; write-only areas give 0.
    always_comb begin
        unique case (region)
            RG_WRAM: rd_mux = wram_rd;
            RG_BIOS: rd_mux = bios_rd;
            RG_WAVE: rd_mux = {{(DATA_W-WAVE_DW){1'b0}}, wave_rd};
            RG_STAT: rd_mux = STAT_NOT_READY;
            default: rd_mux = '0;
        endcase
    end

    // Capture read data on the strobe and hold it until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (cpu_rd) rdata_q <= rd_mux;
    end

    assign cpu_rdata    = rdata_q;
    assign mirror_horiz = mirror_q;
    assign io_enable    = ioen_q;
    assign ctrl_byte    = ctrl_q;

endmodule

// File: rtl/dbd_checker.sv
// Module: dbd_checker
// Bus-level properties of disk_bus_decoder, attached by bind below.
// Assumes the same clock and synchronous active-low reset as the decoder.
module dbd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic        wdata_b3,
    input logic [7:0]  cpu_rdata,
    input logic        mirror_horiz
);

    p_wave_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr >= 16'h4040 && cpu_addr <= 16'h407F)
        |=> cpu_rdata[7:6] == 2'b00);

    p_audio_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr >= 16'h4080 && cpu_addr <= 16'h408F)
        |=> cpu_rdata == 8'h00);

    p_status_not_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr == 16'h4030) |=> cpu_rdata == 8'h80);

    p_mirror_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'h4025) |=> mirror_horiz == $past(wdata_b3));

    p_mirror_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_wr && cpu_addr == 16'h4025) |=> $stable(mirror_horiz));

    p_low_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr < 16'h4020) |=> cpu_rdata == 8'h00);

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(cpu_rdata));

endmodule

bind disk_bus_decoder dbd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_rd       (cpu_rd),
    .cpu_wr       (cpu_wr),
    .wdata_b3     (cpu_wdata[3]),
    .cpu_rdata    (cpu_rdata),
    .mirror_horiz (mirror_horiz)
);

// File: tb/disk_bus_decoder_tb.sv
`timescale 1ns/1ps
module disk_bus_decoder_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [15:0]  cpu_addr = '0;
    logic [7:0]   cpu_wdata = '0;
    logic         cpu_rd = 1'b0;
    logic         cpu_wr = 1'b0;
    logic [7:0]   cpu_rdata;
    logic         mirror_horiz;
    logic [7:0]   io_enable;
    logic [7:0]   ctrl_byte;
    logic [127:0] audio_bank;
    logic         bios_ld_valid = 1'b0;
    logic [7:0]   bios_ld_data = '0;
    logic         bios_ld_restart = 1'b0;

    int checks = 0;
    int failures = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    disk_bus_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .mirror_horiz(mirror_horiz), .io_enable(io_enable), .ctrl_byte(ctrl_byte),
        .audio_bank(audio_bank), .bios_ld_valid(bios_ld_valid),
        .bios_ld_data(bios_ld_data), .bios_ld_restart(bios_ld_restart)
    );

    // Vector: {op 2 (1 write, 2 read-check), addr 16, wdata 8, expect 8, req 4}
    localparam int NV = 21;
    localparam logic [37:0] VEC [NV] = '{
        {2'd1, 16'h6000, 8'hAB, 8'h00, 4'd1},   // R1
        {2'd1, 16'hDFFF, 8'h33, 8'h00, 4'd1},
        {2'd1, 16'h6001, 8'h11, 8'h00, 4'd1},
        {2'd2, 16'h6000, 8'h00, 8'hAB, 4'd1},
        {2'd2, 16'hDFFF, 8'h00, 8'h33, 4'd1},
        {2'd2, 16'h6001, 8'h00, 8'h11, 4'd1},
        {2'd1, 16'h4040, 8'hFF, 8'h00, 4'd4},   // R4
        {2'd1, 16'h407F, 8'h1A, 8'h00, 4'd4},
        {2'd1, 16'h4041, 8'hC5, 8'h00, 4'd4},
        {2'd2, 16'h4040, 8'h00, 8'h3F, 4'd4},
        {2'd2, 16'h407F, 8'h00, 8'h1A, 4'd4},
        {2'd2, 16'h4041, 8'h00, 8'h05, 4'd4},
        {2'd2, 16'h4030, 8'h00, 8'h80, 4'd6},   // R6
        {2'd2, 16'h4031, 8'h00, 8'h00, 4'd6},
        {2'd2, 16'h4033, 8'h00, 8'h00, 4'd6},
        {2'd1, 16'h4080, 8'h7F, 8'h00, 4'd5},   // R5
        {2'd2, 16'h4080, 8'h00, 8'h00, 4'd5},
        {2'd1, 16'h4025, 8'h00, 8'h00, 4'd7},   // R7
        {2'd2, 16'h4025, 8'h00, 8'h00, 4'd7},
        {2'd2, 16'h5123, 8'h00, 8'h00, 4'd9},   // R9
        {2'd2, 16'h402F, 8'h00, 8'h00, 4'd9}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    task automatic bios_load(input int n, input bit alt);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bios_ld_valid = 1'b1;
            bios_ld_data  = alt ? 8'((i + 160) & 255) : pat(i);
        end
        @(negedge clk);
        bios_ld_valid = 1'b0;
    endtask

    task automatic bios_restart();
        @(negedge clk); bios_ld_restart = 1'b1;
        @(negedge clk); bios_ld_restart = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: state right after reset
        check("R11 rdata", cpu_rdata, 0);
        check("R11 mirror", mirror_horiz, 1);
        check("R11 io_enable", io_enable, 0);
        check("R11 ctrl", ctrl_byte, 0);
        check("R11 audio", audio_bank[31:0] | audio_bank[127:96], 0);
        bus_read(16'hE000, rv); check("R2 empty bios", rv, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [37:0] v;
            v = VEC[i];
            if (v[37:36] == 2'd1) begin
                bus_write(v[35:20], v[19:12]);
            end else begin
                bus_read(v[35:20], rv);
                check($sformatf("R%0d vec %0d", v[3:0], i), rv, {24'h0, v[11:4]});
            end
        end

        // R7: mirroring follows control bit 3
        check("R7 mirror vertical", mirror_horiz, 0);
        bus_write(16'h4025, 8'h08);
        check("R7 mirror horizontal", mirror_horiz, 1);
        check("R7 ctrl 08", ctrl_byte, 8'h08);
        bus_write(16'h4025, 8'hF7);
        check("R7 mirror bit3 clear", mirror_horiz, 0);
        check("R7 ctrl F7", ctrl_byte, 8'hF7);

        // R8: I/O enable has no other effect
        bus_write(16'h4023, 8'h5A);
        check("R8 io_enable", io_enable, 8'h5A);
        check("R8 mirror kept", mirror_horiz, 0);
        check("R8 ctrl kept", ctrl_byte, 8'hF7);

        // R5: audio bytes land at their lane
        check("R5 audio lane0", audio_bank[7:0], 8'h7F);
        bus_write(16'h408F, 8'hA5);
        check("R5 audio lane15", audio_bank[127:120], 8'hA5);

        // R9: undecoded writes are ignored
        bus_write(16'h5000, 8'hEE);
        bus_write(16'h4024, 8'hEE);
        bus_write(16'h4030, 8'hEE);
        check("R9 io kept", io_enable, 8'h5A);
        check("R9 ctrl kept", ctrl_byte, 8'hF7);
        check("R9 mirror kept", mirror_horiz, 0);
        check("R9 audio kept", audio_bank[127:120], 8'hA5);
        bus_read(16'h6000, rv); check("R9 wram kept", rv, 8'hAB);
        bus_read(16'h4030, rv); check("R9 status kept", rv, 8'h80);
        bus_read(16'h5000, rv); check("R9 read zero", rv, 0);

        // R1: aliasing of a small work RAM
        bus_write(16'h6800, 8'hCC);
        bus_read(16'h6000, rv); check("R1 alias", rv, 8'hCC);

        // R10: hold while idle, read-before-write
        repeat (3) @(negedge clk);
        check("R10 hold", cpu_rdata, 8'hCC);
        bus_write(16'h6010, 8'h12);
        @(negedge clk);
        cpu_addr = 16'h6010; cpu_wdata = 8'h34; cpu_rd = 1'b1; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        check("R10 old value", cpu_rdata, 8'h12);
        bus_read(16'h6010, rv); check("R10 new value", rv, 8'h34);

        // R2 / R3: BIOS loading and modulo reads
        bios_load(5, 1'b0);
        bus_read(16'hE007, rv); check("R2 mod5 off7", rv, pat(2));
        bus_read(16'hE004, rv); check("R2 off4", rv, pat(4));
        bus_read(16'hFFFF, rv); check("R2 mod5 top", rv, pat(1));
        bios_restart();
        bios_load(1030, 1'b0);
        bus_read(16'hE400, rv); check("R3 saturate", rv, pat(0));
        bus_read(16'hE406, rv); check("R3 wrap 1030", rv, pat(6));
        bus_read(16'hFFFF, rv); check("R3 top byte", rv, pat(1023));
        bios_restart();
        bios_load(2, 1'b1);
        bus_read(16'hE003, rv); check("R3 restart", rv, 8'hA1);

        // R11: reset clears stored state
        bus_write(16'h6000, 8'h55);
        bus_write(16'h4040, 8'h3F);
        do_reset();
        check("R11 mirror after", mirror_horiz, 1);
        check("R11 io after", io_enable, 0);
        check("R11 ctrl after", ctrl_byte, 0);
        check("R11 audio after", audio_bank[127:120] | audio_bank[7:0], 0);
        bus_read(16'h6000, rv); check("R11 wram cleared", rv, 0);
        bus_read(16'h4040, rv); check("R11 wave cleared", rv, 0);
        bus_read(16'hE000, rv); check("R11 bios length cleared", rv, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule